// File: doc/BRIEF.md
# Keyed Watchdog Timer

This peripheral guards a system against runaway software. A 32-bit counter advances on a slow time-base tick, optionally slowed by a power-of-two divider. When the counter wraps from all ones to zero, the block raises a one-cycle reset request and restarts from the programmed start value. Software keeps the system alive by writing a fresh value to a service register before the counter wraps. Each fresh value reloads the counter.

Running and stopping are protected by two-word key sequences written to a key register. The divider settings and the start value cannot be changed while the timer runs. Every register write is posted. A write takes effect only after a fixed number of slow ticks, and a per-register busy flag in the status word shows that the write is still in flight. This mimics a write that crosses into a slow clock domain.

The bus is a single-cycle synchronous write port plus a combinational read port. The word addresses are: 0 divider setup, 1 start value, 2 service, 3 key, 4 status, 5 counter.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the timer is stopped, the status word is 0, the divider setup reads 0, and both the start value and the counter read 0xFFFB0000.
- R2: A committed key of 0xBBBB followed directly by a committed key of 0x4444 starts the timer. Status bit 4 reads 1 while the timer runs.
- R3: A committed key of 0xAAAA followed directly by a committed key of 0x5555 stops the timer.
- R4: If the second key does not directly follow its matching first key, the pair is discarded and the run state stays as it was.
- R5: While the timer runs, writes to the divider setup (address 0) and to the start value (address 1) are ignored. They set no busy flag and change no value.
- R6: An accepted write sets its busy flag in the status word. The flags are bit 0 for divider setup, bit 1 for start value, bit 2 for service and bit 3 for key. The write takes effect on the fourth tick after acceptance, and its busy flag clears on that same tick.
- R7: A write to a register whose busy flag is set is ignored.
- R8: A committed service value that differs from the last committed service value reloads the counter from the start value. An equal value causes no reload.
- R9: With the divider off, a running counter advances by one on every tick. A stopped counter holds its value.
- R10: The divider setup word has bit 0 as the divider enable and bits 3:1 as the exponent k. With the divider on, the counter advances once per 2^k ticks.
- R11: When a running counter wraps past 0xFFFFFFFF, wdReset is high for exactly one clock cycle and the counter reloads from the start value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickIn | input | 1 | One-cycle slow time-base tick enable |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 3 | Write word address |
| wrData | input | 32 | Write data |
| rdAddr | input | 3 | Read word address |
| rdData | output | 32 | Read data (combinational) |
| wdReset | output | 1 | One-cycle reset request on counter wrap |

## Verification
Some properties are checked on every cycle. The reset request lasts a single cycle, is raised only by a running timer, and leaves the counter equal to the start value. A stopped counter never moves except on a service reload, and a running counter with the divider off steps by one per tick. Configuration stays frozen while the timer runs, and busy flags fall only on a tick. Other behaviour can only be shown by the bench's scenarios: the exact key-pair orderings, the four-tick commit latency, writes dropped because a flag is busy, the difference between equal and fresh service values, the divide-by-2^k rate, and the exact cycle on which the timer wraps.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

  localparam int ADDR_W = 3;
  localparam int NUM_WR = 4;

  localparam int IDX_CFG  = 0;
  localparam int IDX_LOAD = 1;
  localparam int IDX_TRIG = 2;
  localparam int IDX_KEY  = 3;

  localparam logic [ADDR_W-1:0] ADDR_STAT  = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_COUNT = 3'd5;

  localparam logic [15:0] KEY_START_A = 16'hBBBB;
  localparam logic [15:0] KEY_START_B = 16'h4444;
  localparam logic [15:0] KEY_STOP_A  = 16'hAAAA;
  localparam logic [15:0] KEY_STOP_B  = 16'h5555;

  typedef enum logic [1:0] {
    KeyIdle     = 2'd0,
    KeyArmStart = 2'd1,
    KeyArmStop  = 2'd2
  } keyState_e;

  typedef struct packed {
    logic cfgCommit;
    logic loadCommit;
    logic reload;
    logic running;
  } dpStrobe_t;

endpackage

// File: rtl/kwd_ctrl.sv
module kwd_ctrl
  import kwd_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int COMMIT_TICKS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output dpStrobe_t         strobe,
  output logic [DATA_W-1:0] cfgStage,
  output logic [DATA_W-1:0] loadStage,
  output logic [NUM_WR-1:0] pendVec,
  output logic              running
);

  localparam int CNT_W = (COMMIT_TICKS > 1) ? $clog2(COMMIT_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(COMMIT_TICKS - 1);

  logic [NUM_WR-1:0] accept;
  logic [NUM_WR-1:0] commit;

  // one posted-write slot per writable register
  for (genvar i = 0; i < NUM_WR; i++) begin : g_slot
    localparam bit LOCKED = (i == IDX_CFG) || (i == IDX_LOAD);
    logic              pendReg;
    logic [CNT_W-1:0]  tickCnt;
    logic [DATA_W-1:0] stageReg;

    assign accept[i] = wrEn && (wrAddr == ADDR_W'(i)) && !pendReg
                       && !(LOCKED && running);
    assign commit[i] = pendReg && tickIn && (tickCnt == LAST_TICK);
    assign pendVec[i] = pendReg;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendReg  <= 1'b0;
        tickCnt  <= '0;
        stageReg <= '0;
      end else if (accept[i]) begin
        pendReg  <= 1'b1;
        tickCnt  <= '0;
        stageReg <= wrData;
      end else if (pendReg && tickIn) begin
        if (tickCnt == LAST_TICK) pendReg <= 1'b0;
        else                      tickCnt <= tickCnt + 1'b1;
      end
    end
  end

  logic [DATA_W-1:0] trigStore;
  logic [DATA_W-1:0] trigVal;
  logic [DATA_W-1:0] keyVal;
  keyState_e         keyState;
  logic              trigFresh;

  assign trigVal   = g_slot[IDX_TRIG].stageReg;
  assign keyVal    = g_slot[IDX_KEY].stageReg;
  assign trigFresh = commit[IDX_TRIG] && (trigVal != trigStore);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trigStore <= '0;
    end else if (trigFresh) begin
      trigStore <= trigVal;
    end
  end

  // key pair sequencing, evaluated on each key commit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyState <= KeyIdle;
      running  <= 1'b0;
    end else if (commit[IDX_KEY]) begin
      if (keyVal == DATA_W'(KEY_START_A)) begin
        keyState <= KeyArmStart;
      end else if (keyVal == DATA_W'(KEY_STOP_A)) begin
        keyState <= KeyArmStop;
      end else begin
        keyState <= KeyIdle;
        if ((keyVal == DATA_W'(KEY_START_B)) && (keyState == KeyArmStart))
          running <= 1'b1;
        if ((keyVal == DATA_W'(KEY_STOP_B)) && (keyState == KeyArmStop))
          running <= 1'b0;
      end
    end
  end

  always_comb begin
    strobe.cfgCommit  = commit[IDX_CFG];
    strobe.loadCommit = commit[IDX_LOAD];
    strobe.reload     = trigFresh;
    strobe.running    = running;
  end

  assign cfgStage  = g_slot[IDX_CFG].stageReg;
  assign loadStage = g_slot[IDX_LOAD].stageReg;

endmodule

// File: rtl/kwd_datapath.sv
module kwd_datapath
  import kwd_pkg::*;
#(
  parameter int              DATA_W   = 32,
  parameter int              PTV_W    = 3,
  parameter logic [DATA_W-1:0] LOAD_RST = 32'hFFFB_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] cfgStage,
  input  logic [DATA_W-1:0] loadStage,
  output logic [DATA_W-1:0] cfgWord,
  output logic [DATA_W-1:0] loadWord,
  output logic [DATA_W-1:0] countWord,
  output logic              wdReset
);

  localparam int DIV_W = (1 << PTV_W);

  logic              preEn;
  logic [PTV_W-1:0]  ptv;
  logic [DIV_W-1:0]  divCnt;
  logic [DIV_W-1:0]  divLast;
  logic              scaledTick;

  assign divLast    = (DIV_W'(1) << ptv) - DIV_W'(1);
  assign scaledTick = strobe.running && tickIn && (!preEn || (divCnt == divLast));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preEn <= 1'b0;
      ptv   <= '0;
    end else if (strobe.cfgCommit) begin
      preEn <= cfgStage[0];
      ptv   <= cfgStage[PTV_W:1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadWord <= LOAD_RST;
    end else if (strobe.loadCommit) begin
      loadWord <= loadStage;
    end
  end

  // tick divider, idle at zero while stopped
  always_ff @(posedge clk) begin
    if (!rstN || !strobe.running) begin
      divCnt <= '0;
    end else if (tickIn) begin
      if (!preEn || (divCnt == divLast)) divCnt <= '0;
      else                               divCnt <= divCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countWord <= LOAD_RST;
      wdReset   <= 1'b0;
    end else begin
      wdReset <= 1'b0;
      if (strobe.reload) begin
        countWord <= loadWord;
      end else if (scaledTick) begin
        if (&countWord) begin
          countWord <= loadWord;
          wdReset   <= 1'b1;
        end else begin
          countWord <= countWord + 1'b1;
        end
      end
    end
  end

  assign cfgWord = {{(DATA_W-PTV_W-1){1'b0}}, ptv, preEn};

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwd_pkg::*;
#(
  parameter int                DATA_W       = 32,
  parameter int                PTV_W        = 3,
  parameter int                COMMIT_TICKS = 4,
  parameter logic [DATA_W-1:0] LOAD_RST     = 32'hFFFB_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              wdReset
);

  dpStrobe_t         strobe;
  logic [DATA_W-1:0] cfgStage;
  logic [DATA_W-1:0] loadStage;
  logic [NUM_WR-1:0] pendVec;
  logic              running;
  logic [DATA_W-1:0] cfgWord;
  logic [DATA_W-1:0] loadWord;
  logic [DATA_W-1:0] countWord;

  kwd_ctrl #(
    .DATA_W      (DATA_W),
    .COMMIT_TICKS(COMMIT_TICKS)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tickIn   (tickIn),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .strobe   (strobe),
    .cfgStage (cfgStage),
    .loadStage(loadStage),
    .pendVec  (pendVec),
    .running  (running)
  );

  kwd_datapath #(
    .DATA_W  (DATA_W),
    .PTV_W   (PTV_W),
    .LOAD_RST(LOAD_RST)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .tickIn   (tickIn),
    .strobe   (strobe),
    .cfgStage (cfgStage),
    .loadStage(loadStage),
    .cfgWord  (cfgWord),
    .loadWord (loadWord),
    .countWord(countWord),
    .wdReset  (wdReset)
  );

  always_comb begin
    case (rdAddr)
      ADDR_W'(IDX_CFG):  rdData = cfgWord;
      ADDR_W'(IDX_LOAD): rdData = loadWord;
      ADDR_STAT:         rdData = {{(DATA_W-NUM_WR-1){1'b0}}, running, pendVec};
      ADDR_COUNT:        rdData = countWord;
      default:           rdData = '0;
    endcase
  end

endmodule

// File: rtl/kwd_checker.sv
module kwd_checker
  import kwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickIn,
  input logic              running,
  input logic [NUM_WR-1:0] pendVec,
  input logic [DATA_W-1:0] cfgWord,
  input logic [DATA_W-1:0] loadWord,
  input logic [DATA_W-1:0] countWord,
  input logic              wdReset
);

  logic reloadSlot;
  assign reloadSlot = pendVec[IDX_TRIG] && tickIn;

  p_pulse_width_r11: assert property (@(posedge clk) disable iff (!rstN)
    wdReset |=> !wdReset);

  p_wrap_reload_r11: assert property (@(posedge clk) disable iff (!rstN)
    wdReset |-> (countWord == loadWord));

  p_wrap_needs_run_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdReset) |-> $past(running));

  p_hold_stopped_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !reloadSlot) |=> $stable(countWord));

  p_step_one_r9: assert property (@(posedge clk) disable iff (!rstN)
    (running && tickIn && !cfgWord[0] && !reloadSlot && !(&countWord))
    |=> (countWord == $past(countWord) + 1'b1));

  p_cfg_locked_r5: assert property (@(posedge clk) disable iff (!rstN)
    (running && !pendVec[IDX_CFG]) |=> $stable(cfgWord));

  p_load_locked_r5: assert property (@(posedge clk) disable iff (!rstN)
    (running && !pendVec[IDX_LOAD]) |=> $stable(loadWord));

  for (genvar k = 0; k < NUM_WR; k++) begin : g_pend
    p_pend_clear_on_tick_r6: assert property (@(posedge clk) disable iff (!rstN)
      $fell(pendVec[k]) |-> $past(tickIn));
  end

endmodule

bind keyed_watchdog kwd_checker #(.DATA_W(DATA_W)) i_kwd_checker (
  .clk      (clk),
  .rstN     (rstN),
  .tickIn   (tickIn),
  .running  (running),
  .pendVec  (pendVec),
  .cfgWord  (cfgWord),
  .loadWord (loadWord),
  .countWord(countWord),
  .wdReset  (wdReset)
);

// File: tb/test_keyed_watchdog.sv
module test_keyed_watchdog;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickIn = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        wdReset;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  keyed_watchdog i_keyed_watchdog (
    .clk    (clk),
    .rstN   (rstN),
    .tickIn (tickIn),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdAddr (rdAddr),
    .rdData (rdData),
    .wdReset(wdReset)
  );

  localparam logic [2:0] A_CFG = 3'd0, A_LOAD = 3'd1, A_TRIG = 3'd2,
                         A_KEY = 3'd3, A_STAT = 3'd4, A_CNT = 3'd5;

  typedef struct packed {
    logic [2:0]  wa;
    logic [31:0] wd;
    logic [2:0]  ra;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{A_CFG,  32'h7,        A_CFG,  32'h7},
    '{A_CFG,  32'h0,        A_CFG,  32'h0},
    '{A_LOAD, 32'hFFFFFF00, A_LOAD, 32'hFFFFFF00},
    '{A_KEY,  32'hBBBB,     A_STAT, 32'h00},
    '{A_KEY,  32'h4444,     A_STAT, 32'h10},
    '{A_KEY,  32'hAAAA,     A_STAT, 32'h10},
    '{A_KEY,  32'h5555,     A_STAT, 32'h00},
    '{A_KEY,  32'hBBBB,     A_STAT, 32'h00},
    '{A_KEY,  32'h1234,     A_STAT, 32'h00},
    '{A_KEY,  32'h4444,     A_STAT, 32'h00}
  };

  function automatic string vecTag(int i);
    case (i)
      0, 1:    return "R10";
      2:       return "R6";
      3, 4:    return "R2";
      5, 6:    return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    tickIn = 1'b1;
    @(negedge clk);
    tickIn = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    rdAddr = a;
    #0.5;
    d = rdData;
  endtask

  task automatic wrCommit(logic [2:0] a, logic [31:0] d);
    wr(a, d);
    ticks(4);
  endtask

  task automatic expectReg(string tag, logic [2:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    expectReg("R1 status", A_STAT, 32'h0);
    expectReg("R1 cfg",    A_CFG,  32'h0);
    expectReg("R1 load",   A_LOAD, 32'hFFFB0000);
    expectReg("R1 count",  A_CNT,  32'hFFFB0000);
    check("R1 wdReset", {31'b0, wdReset}, 32'h0);

    // table of committed writes and read-back expectations
    for (int i = 0; i < NV; i++) begin
      wrCommit(VECS[i].wa, VECS[i].wd);
      expectReg(vecTag(i), VECS[i].ra, VECS[i].exp);
    end

    // R6 pending flag and commit latency, R7 write while pending
    wr(A_LOAD, 32'h200);
    expectReg("R6 pending set", A_STAT, 32'h02);
    wr(A_LOAD, 32'h300);
    ticks(3);
    expectReg("R6 before commit", A_LOAD, 32'hFFFFFF00);
    expectReg("R6 still pending", A_STAT, 32'h02);
    tick();
    expectReg("R6 committed", A_LOAD, 32'h200);
    expectReg("R6 pending clear", A_STAT, 32'h00);
    expectReg("R7 second write dropped", A_LOAD, 32'h200);

    // R9 counting from a reload, R2 start
    wrCommit(A_LOAD, 32'h100);
    wrCommit(A_TRIG, 32'h1);
    expectReg("R8 reload while stopped", A_CNT, 32'h100);
    ticks(3);
    expectReg("R9 stopped holds", A_CNT, 32'h100);
    wrCommit(A_KEY, 32'hBBBB);
    wrCommit(A_KEY, 32'h4444);
    expectReg("R2 running", A_STAT, 32'h10);
    ticks(5);
    expectReg("R9 count by one", A_CNT, 32'h105);

    // R8 equal value no reload, fresh value reloads
    wrCommit(A_TRIG, 32'h1);
    expectReg("R8 same value", A_CNT, 32'h109);
    wrCommit(A_TRIG, 32'h2);
    expectReg("R8 fresh value", A_CNT, 32'h100);

    // R5 locked configuration while running
    wr(A_CFG, 32'h7);
    expectReg("R5 cfg no pending", A_STAT, 32'h10);
    ticks(4);
    expectReg("R5 cfg unchanged", A_CFG, 32'h0);
    wr(A_LOAD, 32'h55);
    ticks(4);
    expectReg("R5 load unchanged", A_LOAD, 32'h100);

    // R10 divider 2^1
    wrCommit(A_KEY, 32'hAAAA);
    wrCommit(A_KEY, 32'h5555);
    expectReg("R3 stopped", A_STAT, 32'h00);
    wrCommit(A_CFG, 32'h3);
    wrCommit(A_TRIG, 32'h3);
    wrCommit(A_KEY, 32'hBBBB);
    wrCommit(A_KEY, 32'h4444);
    expectReg("R10 start value", A_CNT, 32'h100);
    ticks(8);
    expectReg("R10 half rate", A_CNT, 32'h104);
    tick();
    expectReg("R10 odd tick no step", A_CNT, 32'h104);

    // R11 wrap
    wrCommit(A_KEY, 32'hAAAA);
    wrCommit(A_KEY, 32'h5555);
    wrCommit(A_CFG, 32'h0);
    wrCommit(A_LOAD, 32'hFFFFFFFC);
    wrCommit(A_TRIG, 32'h4);
    wrCommit(A_KEY, 32'hBBBB);
    wrCommit(A_KEY, 32'h4444);
    ticks(3);
    expectReg("R11 at max", A_CNT, 32'hFFFFFFFF);
    check("R11 no request yet", {31'b0, wdReset}, 32'h0);
    tick();
    check("R11 request high", {31'b0, wdReset}, 32'h1);
    expectReg("R11 reloaded", A_CNT, 32'hFFFFFFFC);
    @(negedge clk);
    check("R11 request one cycle", {31'b0, wdReset}, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

endmodule